// File: doc/BRIEF.md
# Read/Write Strobe Handshake Sequencer

This block sits between a parallel bus and a local peripheral. It runs exactly one transfer at a time, either a read or a write. The bus requests a transfer by raising one of two strobes. The sequencer then talks to the peripheral through a request/acknowledge pair and gates the data transceiver. It answers the bus with an acknowledge once the data is valid, and all signals return to zero under four-phase rules.

The three inputs arrive asynchronously and each passes through a multi-stage synchronizer. A synchronous state machine then orders every output edge. The read and write sequences raise the transceiver enable at different points and release signals in different orders. Some of the visible output combinations appear in both directions. The state register, which records the direction, keeps those phases apart.

A new device request is never issued while the previous device acknowledge is still high, even when the bus raises its next strobe early. If both strobes are seen high while the sequencer is idle, it flags a protocol error and starts nothing.

Top module: `hs_bus_bridge`

## Requirements
- R1: A synchronous active-high reset forces every output to 0 at the next rising clock edge, and the sequencer returns to idle. Outputs stay 0 after reset until a strobe is applied.
- R2: Each input passes through SYNC_STAGES flops (default 2), and outputs are registered. An output that responds to an input change therefore moves exactly SYNC_STAGES+1 rising edges after the change. Each output changes at most once per clock.
- R3: Read ordering works as follows. When the read strobe rises, the device request rises. After the device acknowledge rises, the transceiver enable rises. One clock later, the bus acknowledge rises.
- R4: Read return works as follows. When the read strobe falls, the transceiver enable falls first. One clock later, the device request and the bus acknowledge fall together.
- R5: Write ordering works as follows. When the write strobe rises, the transceiver enable rises, and the device request follows one clock later. After the device acknowledge rises, the transceiver enable falls. One clock later, the bus acknowledge rises.
- R6: Write return works as follows. When the write strobe falls, the device request and the bus acknowledge fall in the same clock.
- R7: The device request never rises while the synchronized device acknowledge is high. A strobe that arrives before the acknowledge has been released is held off. The request then rises SYNC_STAGES+1 edges after the acknowledge falls.
- R8: In idle, if both strobes are seen high, the protocol error flag is set and all other outputs stay 0. Once only one strobe remains high, the flag clears and that strobe's cycle starts in the same clock.
- R9: The bus acknowledge stays high for as long as the active strobe stays high, whatever the hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_strobe_i | input | 1 | Bus read strobe (asynchronous) |
| wr_strobe_i | input | 1 | Bus write strobe (asynchronous) |
| dev_ack_i | input | 1 | Peripheral acknowledge (asynchronous) |
| dev_req_o | output | 1 | Request strobe to the peripheral |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge returned to the bus |
| proto_err_o | output | 1 | Both strobes seen high while idle |

## Verification
An output that answers an input edge is due three rising edges after the input is driven: two synchronizer flops and one state/output register. An output that follows another output is due one edge later. The bench drives inputs on falling edges and counts falling edges until the full output vector reaches the expected value. A check fails if the count is not exactly 3 or 1, and the check also confirms that no other output has moved in the meantime. Hold windows, the early-strobe wait and the error dwell sample the full vector on every falling edge of the window.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_XEN,
        ST_RD_ACK,
        ST_RD_XOFF,
        ST_WR_XEN,
        ST_WR_REQ,
        ST_WR_XOFF,
        ST_WR_ACK
    } hsc_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ack;
    } hsc_in_s;

    typedef struct packed {
        logic err;
        logic dev_req;
        logic xcvr;
        logic bus_ack;
    } hsc_out_s;

    localparam int unsigned HSC_IN_W  = $bits(hsc_in_s);
    localparam int unsigned HSC_OUT_W = $bits(hsc_out_s);

    // Output pattern owned by each state; err is supplied separately.
    function automatic hsc_out_s out_of(hsc_state_e s, logic err);
        hsc_out_s o;
        o = '0;
        o.err = err;
        case (s)
            ST_RD_REQ:  o.dev_req = 1'b1;
            ST_RD_XEN:  begin o.dev_req = 1'b1; o.xcvr = 1'b1; end
            ST_RD_ACK:  begin o.dev_req = 1'b1; o.xcvr = 1'b1; o.bus_ack = 1'b1; end
            ST_RD_XOFF: begin o.dev_req = 1'b1; o.bus_ack = 1'b1; end
            ST_WR_XEN:  o.xcvr = 1'b1;
            ST_WR_REQ:  begin o.dev_req = 1'b1; o.xcvr = 1'b1; end
            ST_WR_XOFF: o.dev_req = 1'b1;
            ST_WR_ACK:  begin o.dev_req = 1'b1; o.bus_ack = 1'b1; end
            default:    o.err = err;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/hsc_seq.sv
module hsc_seq
    import hsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hsc_in_s    in_s,
    output hsc_out_s   out_q,
    output hsc_state_e state_q
);
    hsc_state_e state_d;
    logic       err_d;
    logic       both;

    assign both = in_s.rd && in_s.wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!both && !in_s.ack) begin
                    if (in_s.rd)      state_d = ST_RD_REQ;
                    else if (in_s.wr) state_d = ST_WR_XEN;
                end
            end
            ST_RD_REQ:  if (in_s.ack) state_d = ST_RD_XEN;
            ST_RD_XEN:  state_d = ST_RD_ACK;
            ST_RD_ACK:  if (!in_s.rd) state_d = ST_RD_XOFF;
            ST_RD_XOFF: state_d = ST_IDLE;
            ST_WR_XEN:  state_d = ST_WR_REQ;
            ST_WR_REQ:  if (in_s.ack) state_d = ST_WR_XOFF;
            ST_WR_XOFF: state_d = ST_WR_ACK;
            ST_WR_ACK:  if (!in_s.wr) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign err_d = (state_d == ST_IDLE) && both;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            out_q   <= out_of(state_d, err_d);
        end
    end
endmodule

// File: rtl/hs_bus_bridge.sv
module hs_bus_bridge
    import hsc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe_i,
    input  logic wr_strobe_i,
    input  logic dev_ack_i,
    output logic dev_req_o,
    output logic xcvr_en_o,
    output logic bus_ack_o,
    output logic proto_err_o
);
    logic [HSC_IN_W-1:0] raw_bits;
    logic [HSC_IN_W-1:0] sync_bits;
    hsc_in_s             in_sync;
    hsc_out_s            outs;
    hsc_state_e          state;
    logic                ack_sync;

    assign raw_bits = {rd_strobe_i, wr_strobe_i, dev_ack_i};

    hsc_sync #(
        .WIDTH  (HSC_IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bits),
        .q   (sync_bits)
    );

    assign in_sync  = hsc_in_s'(sync_bits);
    assign ack_sync = in_sync.ack;

    hsc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_s    (in_sync),
        .out_q   (outs),
        .state_q (state)
    );

    assign dev_req_o   = outs.dev_req;
    assign xcvr_en_o   = outs.xcvr;
    assign bus_ack_o   = outs.bus_ack;
    assign proto_err_o = outs.err && (state == ST_IDLE);
endmodule

// File: rtl/hs_bus_bridge_chk.sv
module hs_bus_bridge_chk (
    input logic clk,
    input logic rst,
    input logic ack_sync,
    input logic dev_req,
    input logic xcvr,
    input logic bus_ack,
    input logic err
);
    assert_req_waits_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_req) |-> !$past(ack_sync));

    assert_busack_under_req_R3: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> dev_req);

    assert_joint_return_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack) |-> $fell(dev_req));

    assert_xcvr_off_at_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_req) |-> !xcvr);

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (!dev_req && !xcvr && !bus_ack));

    assert_xcvr_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(xcvr) |-> (!dev_req || $past(ack_sync)));
endmodule

bind hs_bus_bridge hs_bus_bridge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_sync (ack_sync),
    .dev_req  (dev_req_o),
    .xcvr     (xcvr_en_o),
    .bus_ack  (bus_ack_o),
    .err      (proto_err_o)
);

// File: tb/test_hs_bus_bridge.sv
`timescale 1ns/1ps
module test_hs_bus_bridge;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
    logic dev_req, xcvr, bus_ack, err;
    int   checks = 0;
    int   fails  = 0;

    always #4 clk = ~clk;

    hs_bus_bridge i_hs_bus_bridge (
        .clk(clk), .rst(rst),
        .rd_strobe_i(rd), .wr_strobe_i(wr), .dev_ack_i(ack),
        .dev_req_o(dev_req), .xcvr_en_o(xcvr), .bus_ack_o(bus_ack),
        .proto_err_o(err)
    );

    // Vector fields: [15] write, [14:12] response latency, [11:6] ack delay, [5:0] hold
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 3'd3, 6'd0,  6'd0},
        {1'b1, 3'd3, 6'd0,  6'd0},
        {1'b0, 3'd3, 6'd5,  6'd2},
        {1'b1, 3'd3, 6'd7,  6'd4},
        {1'b0, 3'd3, 6'd1,  6'd9},
        {1'b1, 3'd3, 6'd12, 6'd1}
    };

    function automatic logic [3:0] outs();
        return {err, dev_req, xcvr, bus_ack};
    endfunction

    task automatic wait_for(input logic [3:0] exp, input int exp_cnt, input string tag);
        int n = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (outs() == exp) begin n = i; break; end
        end
        checks++;
        if (n != exp_cnt) begin
            fails++;
            $display("FAIL %s: got %b after %0d cycles, expected %b after %0d", tag, outs(), n, exp, exp_cnt);
        end
    endtask

    task automatic hold(input logic [3:0] exp, input int cycles, input string tag);
        int bad = 0;
        logic [3:0] seen = exp;
        if (cycles == 0) return;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (outs() != exp) begin bad++; seen = outs(); end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: got %b, expected %b held", tag, seen, exp);
        end
    endtask

    task automatic do_read(input int lat, input int adly, input int rel);
        rd = 1'b1;
        wait_for(4'b0100, lat, "R2 R3 request rise");
        repeat (adly) @(negedge clk);
        ack = 1'b1;
        wait_for(4'b0110, lat, "R3 transceiver rise");
        wait_for(4'b0111, 1, "R3 bus ack rise");
        hold(4'b0111, rel, "R9 bus ack hold");
        rd = 1'b0;
        wait_for(4'b0101, lat, "R4 transceiver fall");
        wait_for(4'b0000, 1, "R4 joint release");
        ack = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_write(input int lat, input int adly, input int rel);
        wr = 1'b1;
        wait_for(4'b0010, lat, "R2 R5 transceiver rise");
        wait_for(4'b0110, 1, "R5 request rise");
        repeat (adly) @(negedge clk);
        ack = 1'b1;
        wait_for(4'b0100, lat, "R5 transceiver fall");
        wait_for(4'b0101, 1, "R5 bus ack rise");
        hold(4'b0101, rel, "R9 bus ack hold");
        wr = 1'b0;
        wait_for(4'b0000, lat, "R6 joint release");
        ack = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (outs() !== 4'b0000) begin
            fails++;
            $display("FAIL R1 reset: got %b, expected 0000", outs());
        end
        rst = 1'b0;
        hold(4'b0000, 5, "R1 idle after reset");

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][15]) do_write(int'(VEC[v][14:12]), int'(VEC[v][11:6]), int'(VEC[v][5:0]));
            else            do_read (int'(VEC[v][14:12]), int'(VEC[v][11:6]), int'(VEC[v][5:0]));
        end

        // R7: early strobe while device ack is still high
        rd = 1'b1;
        wait_for(4'b0100, 3, "R7 first request");
        ack = 1'b1;
        wait_for(4'b0110, 3, "R7 transceiver");
        wait_for(4'b0111, 1, "R7 bus ack");
        rd = 1'b0;
        wait_for(4'b0101, 3, "R7 transceiver fall");
        wait_for(4'b0000, 1, "R7 release");
        rd = 1'b1;
        hold(4'b0000, 8, "R7 request held off");
        ack = 1'b0;
        wait_for(4'b0100, 3, "R7 request after release");
        ack = 1'b1;
        wait_for(4'b0110, 3, "R7 second transceiver");
        wait_for(4'b0111, 1, "R7 second bus ack");
        rd = 1'b0;
        wait_for(4'b0000, 4, "R7 second release");
        ack = 1'b0;
        repeat (4) @(negedge clk);

        // R8: both strobes in idle
        rd = 1'b1; wr = 1'b1;
        wait_for(4'b1000, 3, "R8 error flag");
        hold(4'b1000, 5, "R8 no cycle");
        wr = 1'b0;
        wait_for(4'b0100, 3, "R8 clear and read start");
        ack = 1'b1;
        wait_for(4'b0111, 4, "R8 read completes");
        rd = 1'b0;
        wait_for(4'b0000, 4, "R8 release");
        ack = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset in mid-write
        wr = 1'b1;
        wait_for(4'b0010, 3, "R5 mid-write start");
        wait_for(4'b0110, 1, "R5 mid-write request");
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (outs() !== 4'b0000) begin
            fails++;
            $display("FAIL R1 mid-cycle reset: got %b, expected 0000", outs());
        end
        wr = 1'b0;
        rst = 1'b0;
        hold(4'b0000, 6, "R1 quiet after reset");

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end
endmodule